// File: doc/BRIEF.md
# Configuration Command Register Controller

This block is a small group of three memory-mapped registers: a data word, a command word and a completion status. Software writes a command word into the command register. The write completes in the same cycle, and the block decodes the stored value into a system-level request. Two exact encodings are recognised. One asks for a power-down of the system and the other asks for a restart. Each is delivered as a single-cycle pulse. Any other command is marked as failed in the status register.

The whole group exists only on one board type. A strap word carries a 12-bit board identity field in bits 27:16. When that field does not equal the parameterised match value (0x190 by default), the registers are hidden. An access to them reads zero, changes nothing and raises a one-cycle bad-access pulse. An access to any offset outside the group raises the same pulse and reads zero. The serial configuration bus that would sit behind these registers in a full system is not modelled.

Top module: `cfgcmd_ctrl`

## Requirements
- R1: After reset, all three registers read zero and the shutdown, reboot and bad-access outputs are low.
- R2: The data register at offset 0xA0 returns the last full 32-bit word written to it.
- R3: A write to the command register at offset 0xA4 stores the written word with bits 19 and 18 forced to zero. A read returns the stored value.
- R4: Every command write that the block accepts leaves bit 0 (done) of the status register at offset 0xA8 set.
- R5: A stored command of 0xC0800000 produces a shutdown pulse, and a stored command of 0xC0900000 produces a reboot pulse. The pulse is high in the cycle after the write edge, and it applies even when the written word differs only in bits 19:18.
- R6: Any other stored command gives status 3 (done plus error in bit 1) and raises no request.
- R7: A write to the status register keeps only bits 1:0 of the written word.
- R8: When strap bits 27:16 differ from 0x190, a read of any of the three registers returns zero and a write changes no register.
- R9: An access to an unmapped offset, or to the group while it is disabled, raises bad_access for exactly one cycle, in the cycle after the access. Such a read returns zero.
- R10: The shutdown and reboot outputs are single-cycle pulses, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_id | input | 32 | Board strap word; bits 27:16 hold the board identity |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational, zero when not a valid read of the group |
| shutdown_req | output | 1 | One-cycle power-down request |
| reboot_req | output | 1 | One-cycle restart request |
| bad_access | output | 1 | One-cycle flag for an unmapped or disabled access |

## Verification
The command register is driven with both exact encodings, with those encodings plus bits 19:18 set (which must still match after masking), with an all-ones word and with an encoding one bit away from a valid one. Together these patterns separate a correct mask-then-compare from a compare on the raw word, and from a compare that ignores low bits. The status register is written with words whose upper bits are set, which shows whether the two-bit truncation is present. The strap is toggled away from the board match and back. This shows that writes are dropped while the group is hidden and that stored values survive and reappear. Reads and writes to an unmapped offset show that the bad-access pulse is separate from the group's own traffic.

// File: rtl/cfgcmd_pkg.sv
package cfgcmd_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int CMD_W      = 32;
  localparam int STAT_W     = 2;
  localparam int NUM_CMDS   = 2;

  // bits cleared on every command store
  localparam logic [CMD_W-1:0] CMD_STORE_MASK = ~(32'h3 << 18);

  // recognised command encodings, index order fixes output order
  localparam logic [CMD_W-1:0] CMD_POWER_DOWN = 32'hC080_0000;
  localparam logic [CMD_W-1:0] CMD_RESTART    = 32'hC090_0000;

  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;

endpackage

// File: rtl/cfgcmd_rst_sync.sv
module cfgcmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cfgcmd_decode.sv
module cfgcmd_decode
  import cfgcmd_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                STRAP_W    = 32,
  parameter int                ID_LSB     = 16,
  parameter int                ID_W       = 12,
  parameter logic [ID_W-1:0]   BOARD_SEL  = 12'h190,
  parameter logic [ADDR_W-1:0] OFS_DATA   = 8'hA0,
  parameter logic [ADDR_W-1:0] OFS_CMD    = 8'hA4,
  parameter logic [ADDR_W-1:0] OFS_STAT   = 8'hA8
) (
  input  logic [STRAP_W-1:0] strap_id,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic               grp_en,
  output reg_sel_e           rd_sel,
  output logic               wr_data,
  output logic               wr_cmd,
  output logic               wr_stat,
  output logic               bad_hit
);

  localparam int ID_MSB = ID_LSB + ID_W - 1;

  reg_sel_e addr_sel;
  logic     live;

  always_comb begin
    unique case (acc_addr)
      OFS_DATA: addr_sel = SEL_DATA;
      OFS_CMD:  addr_sel = SEL_CMD;
      OFS_STAT: addr_sel = SEL_STAT;
      default:  addr_sel = SEL_NONE;
    endcase
  end

  assign grp_en = (strap_id[ID_MSB:ID_LSB] == BOARD_SEL);
  assign live   = acc_valid && grp_en && (addr_sel != SEL_NONE);

  always_comb begin
    rd_sel  = SEL_NONE;
    wr_data = 1'b0;
    wr_cmd  = 1'b0;
    wr_stat = 1'b0;
    if (live) begin
      if (acc_write) begin
        wr_data = (addr_sel == SEL_DATA);
        wr_cmd  = (addr_sel == SEL_CMD);
        wr_stat = (addr_sel == SEL_STAT);
      end else begin
        rd_sel = addr_sel;
      end
    end
  end

  assign bad_hit = acc_valid && !live;

endmodule

// File: rtl/cfgcmd_cmd.sv
module cfgcmd_cmd
  import cfgcmd_pkg::*;
(
  input  logic [CMD_W-1:0]  wr_word,
  output logic [CMD_W-1:0]  cmd_store,
  output logic [STAT_W-1:0] cmd_status,
  output logic              hit_power_down,
  output logic              hit_restart
);

  localparam logic [CMD_W-1:0] CODES [NUM_CMDS] = '{CMD_POWER_DOWN, CMD_RESTART};

  logic [NUM_CMDS-1:0] match;

  assign cmd_store = wr_word & CMD_STORE_MASK;

  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_match
    assign match[i] = (cmd_store == CODES[i]);
  end

  assign hit_power_down = match[0];
  assign hit_restart    = match[1];

  always_comb begin
    cmd_status                = '0;
    cmd_status[STAT_DONE_BIT] = 1'b1;
    cmd_status[STAT_ERR_BIT]  = ~|match;
  end

endmodule

// File: rtl/cfgcmd_regs.sv
module cfgcmd_regs
  import cfgcmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic              wr_cmd,
  input  logic              wr_stat,
  input  logic              bad_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CMD_W-1:0]  cmd_store,
  input  logic [STAT_W-1:0] cmd_status,
  input  logic              hit_power_down,
  input  logic              hit_restart,
  output logic [DATA_W-1:0] data_q,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              pd_q,
  output logic              rs_q,
  output logic              bad_q
);

  logic [DATA_W-1:0] data_d;
  logic [CMD_W-1:0]  cmd_d;
  logic [STAT_W-1:0] stat_d;
  logic              data_en, cmd_en, stat_en;

  // next-state
  always_comb begin
    data_en = wr_data;
    data_d  = wdata;
    cmd_en  = wr_cmd;
    cmd_d   = cmd_store;
    stat_en = wr_cmd || wr_stat;
    stat_d  = wr_cmd ? cmd_status : wdata[STAT_W-1:0];
  end

  // storage with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  // single-cycle event outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= 1'b0;
      rs_q  <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      pd_q  <= wr_cmd && hit_power_down;
      rs_q  <= wr_cmd && hit_restart;
      bad_q <= bad_hit;
    end
  end

endmodule

// File: rtl/cfgcmd_ctrl.sv
module cfgcmd_ctrl
  import cfgcmd_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                STRAP_W   = 32,
  parameter int                ID_LSB    = 16,
  parameter int                ID_W      = 12,
  parameter logic [ID_W-1:0]   BOARD_SEL = 12'h190,
  parameter logic [ADDR_W-1:0] OFS_DATA  = 8'hA0,
  parameter logic [ADDR_W-1:0] OFS_CMD   = 8'hA4,
  parameter logic [ADDR_W-1:0] OFS_STAT  = 8'hA8,
  parameter int                SYNC_STG  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_id,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [DATA_W-1:0]  acc_wdata,
  output logic [DATA_W-1:0]  acc_rdata,
  output logic               shutdown_req,
  output logic               reboot_req,
  output logic               bad_access
);

  logic              rst_n_s;
  logic              grp_en;
  reg_sel_e          rd_sel;
  logic              wr_data, wr_cmd, wr_stat, bad_hit;
  logic [CMD_W-1:0]  cmd_store;
  logic [STAT_W-1:0] cmd_status;
  logic              hit_power_down, hit_restart;
  logic [DATA_W-1:0] data_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [STAT_W-1:0] stat_q;

  cfgcmd_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cfgcmd_decode #(
    .ADDR_W    (ADDR_W),
    .STRAP_W   (STRAP_W),
    .ID_LSB    (ID_LSB),
    .ID_W      (ID_W),
    .BOARD_SEL (BOARD_SEL),
    .OFS_DATA  (OFS_DATA),
    .OFS_CMD   (OFS_CMD),
    .OFS_STAT  (OFS_STAT)
  ) u_dec (
    .strap_id  (strap_id),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .grp_en    (grp_en),
    .rd_sel    (rd_sel),
    .wr_data   (wr_data),
    .wr_cmd    (wr_cmd),
    .wr_stat   (wr_stat),
    .bad_hit   (bad_hit)
  );

  cfgcmd_cmd u_cmd (
    .wr_word        (acc_wdata[CMD_W-1:0]),
    .cmd_store      (cmd_store),
    .cmd_status     (cmd_status),
    .hit_power_down (hit_power_down),
    .hit_restart    (hit_restart)
  );

  cfgcmd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .wr_data        (wr_data),
    .wr_cmd         (wr_cmd),
    .wr_stat        (wr_stat),
    .bad_hit        (bad_hit),
    .wdata          (acc_wdata),
    .cmd_store      (cmd_store),
    .cmd_status     (cmd_status),
    .hit_power_down (hit_power_down),
    .hit_restart    (hit_restart),
    .data_q         (data_q),
    .cmd_q          (cmd_q),
    .stat_q         (stat_q),
    .pd_q           (shutdown_req),
    .rs_q           (reboot_req),
    .bad_q          (bad_access)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_DATA: acc_rdata = data_q;
      SEL_CMD:  acc_rdata = DATA_W'(cmd_q);
      SEL_STAT: acc_rdata = DATA_W'(stat_q);
      default:  acc_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfgcmd_ctrl_chk.sv
module cfgcmd_ctrl_chk
  import cfgcmd_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 32,
  parameter logic [ADDR_W-1:0] OFS_CMD = 8'hA4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grp_en,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              shutdown_req,
  input logic              reboot_req,
  input logic [CMD_W-1:0]  cmd_q,
  input logic [STAT_W-1:0] stat_q
);

  logic cmd_wr_ok;
  assign cmd_wr_ok = acc_valid && acc_write && grp_en && (acc_addr == OFS_CMD);

  // R5: a request pulse follows an accepted command write
  a_r5_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req || reboot_req) |-> $past(cmd_wr_ok));

  // R6: a raised request means the command completed without error
  a_r6_req_status_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req || reboot_req) |-> (stat_q == 2'b01));

  // R4: done bit set after every accepted command write
  a_r4_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_ok |=> stat_q[STAT_DONE_BIT]);

  // R10: the two requests never coincide
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req));

  // R8: disabled group reads zero
  a_r8_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !grp_en) |-> (acc_rdata == '0));

  // R8: command register moves only on an accepted command write
  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr_ok |=> $stable(cmd_q));

endmodule

bind cfgcmd_ctrl cfgcmd_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .OFS_CMD (OFS_CMD)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .grp_en       (grp_en),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_addr     (acc_addr),
  .acc_rdata    (acc_rdata),
  .shutdown_req (shutdown_req),
  .reboot_req   (reboot_req),
  .cmd_q        (cmd_q),
  .stat_q       (stat_q)
);

// File: tb/cfgcmd_ctrl_tb_top.sv
module cfgcmd_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] STRAP_OK  = 32'h0190_0000;
  localparam logic [31:0] STRAP_BAD = 32'h0178_0000;

  // vector: wr addr, wr data, rd addr, expected read, exp shutdown, reboot, bad
  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp_rd;
    logic        exp_sd;
    logic        exp_rb;
    logic        exp_bad;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA0, 32'h1234_5678, 8'hA0, 32'h1234_5678, 1'b0, 1'b0, 1'b0}, // R2
    '{8'hA4, 32'hC080_0000, 8'hA8, 32'h0000_0001, 1'b1, 1'b0, 1'b0}, // R4 R5
    '{8'hA4, 32'hC090_0000, 8'hA4, 32'hC090_0000, 1'b0, 1'b1, 1'b0}, // R5 R3
    '{8'hA4, 32'hC08C_0000, 8'hA4, 32'hC080_0000, 1'b1, 1'b0, 1'b0}, // R3 R5
    '{8'hA4, 32'hFFFF_FFFF, 8'hA4, 32'hFFF3_FFFF, 1'b0, 1'b0, 1'b0}, // R3 R6
    '{8'hA0, 32'hDEAD_BEEF, 8'hA8, 32'h0000_0003, 1'b0, 1'b0, 1'b0}, // R6
    '{8'hA8, 32'hFFFF_FFFC, 8'hA8, 32'h0000_0000, 1'b0, 1'b0, 1'b0}, // R7
    '{8'hA8, 32'h0000_000E, 8'hA8, 32'h0000_0002, 1'b0, 1'b0, 1'b0}, // R7
    '{8'h40, 32'h0000_0055, 8'hA0, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1}, // R9
    '{8'hA4, 32'hC080_0001, 8'hA8, 32'h0000_0003, 1'b0, 1'b0, 1'b0}  // R6
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] strap_id;
  logic        acc_valid;
  logic        acc_write;
  logic [7:0]  acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        shutdown_req, reboot_req, bad_access;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgcmd_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_id     (strap_id),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_wdata    (acc_wdata),
    .acc_rdata    (acc_rdata),
    .shutdown_req (shutdown_req),
    .reboot_req   (reboot_req),
    .bad_access   (bad_access)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write at a negedge; outputs registered at the next posedge are sampled at the following negedge
  task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                          output logic sd, output logic rb, output logic bd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    sd = shutdown_req; rb = reboot_req; bd = bad_access;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d,
                         output logic sd, output logic rb, output logic bd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_wdata = '0;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_valid = 1'b0;
    sd = shutdown_req; rb = reboot_req; bd = bad_access;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic sd, rb, bd;
    rst_n = 1'b0; strap_id = STRAP_OK;
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 outputs", {29'd0, shutdown_req, reboot_req, bad_access}, 32'd0);
    do_read(8'hA0, rd, sd, rb, bd); check("R1 data", rd, 32'd0);
    do_read(8'hA4, rd, sd, rb, bd); check("R1 cmd", rd, 32'd0);
    do_read(8'hA8, rd, sd, rb, bd); check("R1 status", rd, 32'd0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      do_write(VECS[i].waddr, VECS[i].wdata, sd, rb, bd);
      check($sformatf("R5 shutdown v%0d", i), {31'd0, sd}, {31'd0, VECS[i].exp_sd});
      check($sformatf("R5 reboot v%0d", i), {31'd0, rb}, {31'd0, VECS[i].exp_rb});
      check($sformatf("R9 bad v%0d", i), {31'd0, bd}, {31'd0, VECS[i].exp_bad});
      do_read(VECS[i].raddr, rd, sd, rb, bd);
      check($sformatf("R2/R3/R6/R7 read v%0d", i), rd, VECS[i].exp_rd);
      check($sformatf("R10 pulse width v%0d", i), {30'd0, sd, rb}, 32'd0);
      check($sformatf("R9 no bad on read v%0d", i), {31'd0, bd}, 32'd0);
    end

    // R9 unmapped read: zero data, one-cycle flag
    do_read(8'h44, rd, sd, rb, bd);
    check("R9 unmapped read data", rd, 32'd0);
    check("R9 unmapped read flag", {31'd0, bd}, 32'd1);
    @(negedge clk);
    check("R9 flag one cycle", {31'd0, bad_access}, 32'd0);

    // R8 hidden group: known state first
    do_write(8'hA0, 32'hCAFE_0001, sd, rb, bd);
    do_write(8'hA4, 32'h0000_1111, sd, rb, bd);
    strap_id = STRAP_BAD;
    do_write(8'hA0, 32'h0BAD_0BAD, sd, rb, bd);
    check("R9 disabled write flag", {31'd0, bd}, 32'd1);
    do_write(8'hA4, 32'hC080_0000, sd, rb, bd);
    check("R8 disabled cmd no request", {30'd0, sd, rb}, 32'd0);
    do_write(8'hA8, 32'h0000_0000, sd, rb, bd);
    do_read(8'hA0, rd, sd, rb, bd);
    check("R8 disabled read zero", rd, 32'd0);
    check("R9 disabled read flag", {31'd0, bd}, 32'd1);
    strap_id = STRAP_OK;
    do_read(8'hA0, rd, sd, rb, bd); check("R8 data untouched", rd, 32'hCAFE_0001);
    do_read(8'hA4, rd, sd, rb, bd); check("R8 cmd untouched", rd, 32'h0000_1111);
    do_read(8'hA8, rd, sd, rb, bd); check("R8 status untouched", rd, 32'd3);

    // R10 back-to-back different commands, one pulse each
    do_write(8'hA4, 32'hC090_0000, sd, rb, bd);
    check("R10 restart only", {30'd0, sd, rb}, 32'd1);
    do_write(8'hA4, 32'hC084_0000, sd, rb, bd);
    check("R10 power-down only", {30'd0, sd, rb}, 32'd2);

    // R1 reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(8'hA4, rd, sd, rb, bd); check("R1 cmd after reset", rd, 32'd0);
    do_read(8'hA8, rd, sd, rb, bd); check("R1 status after reset", rd, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule